// File: doc/BRIEF.md
# Oscillator auto-trim controller

This block tunes a fast on-chip oscillator toward 22.1184 MHz by measuring it against a 32.768 kHz reference. It runs in the oscillator's own clock domain. The reference edge passes through a two-flop synchroniser and a rising-edge detector. Each reference period is then counted in oscillator cycles. The counts are summed over a window of 4, 8, 16 or 32 periods, and the sum is compared with the nominal count scaled by the window length. After every window that falls outside tolerance, the trim code moves one step up or down. A window that falls inside tolerance sets the lock flag.

Trimming stops in hardware in two cases, and in both the enable bit is cleared and a sticky status flag is set. The first case is that the allowed number of trim updates has been used without reaching lock. The second is a single reference period that is too short or too long, which marks the reference as faulty. Software drives the block through three registers: control, interrupt enable, and a status register with write-1-to-clear flags. It receives one interrupt line. The trim code output drives the analog oscillator, which is not part of this block.

Top module: `osc_autotrim`

## Requirements
- R1: After reset, all three registers read 0, `irq_o` is 0 and `trim_code_o` equals `TRIM_INIT`.
- R2: The control register is at address 0. Bit 0 is the enable, bits 5:4 are the window select and bits 7:6 are the retry select. Bits 3:1 read as 0. The register reads back what was written, except where hardware has cleared the enable.
- R3: Once enabled, the first synchronised reference rising edge only starts measurement. Each later rising edge closes one period. A window of `4 << window select` consecutive periods is summed, so the trim decisions are exactly window × period oscillator cycles apart.
- R4: A window sum within `(NOM-TOL)*N` to `(NOM+TOL)*N` inclusive sets the lock flag (status bit 0) and leaves the trim code unchanged.
- R5: A window sum below the range raises the trim code by 1, and a sum above the range lowers it by 1. The code saturates at 0 and at its maximum, and a saturated step still counts as an update.
- R6: The retry select allows `RETRY_BASE << retry select` updates. An out-of-range window that arrives after that many updates sets the fail flag (status bit 1), clears the enable and leaves the trim code unchanged.
- R7: While measuring, a period shorter than `ERR_LO` cycles or longer than `ERR_HI` cycles sets the reference-error flag (status bit 2), clears the enable and the lock flag, and leaves the trim code unchanged.
- R8: Writing 1 to status bit 1 or bit 2 clears that flag, and writing 0 leaves it as it is. The lock bit cannot be written.
- R9: The interrupt-enable register is at address 1, with bit 1 enabling the fail flag and bit 2 enabling the reference-error flag. Its other bits read 0. `irq_o` is high exactly when an enabled flag is set. Lock never raises the interrupt.
- R10: While the enable is 0, the lock flag reads 0 one cycle later, the trim code holds, and the update count and window restart. A new enable therefore begins with a fresh retry budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Low-speed reference clock, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 interrupt enable, 2 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| trim_code_o | output | TRIM_W | Trim code for the oscillator |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with a nominal count of 40 cycles per period, error bounds of 20 and 80, a retry base of 4 and a 6-bit trim code. With these values every retry limit, saturation of the trim code at zero and both reference-error directions can be reached within a few thousand cycles. A reference model in the bench shifts the trim code's effect into the reference period and follows the design cycle by cycle. Directed phases then measure the spacing between decisions for two window lengths, the trim code at the fail point, and the write-1-to-clear and interrupt-mask behaviour.

// File: rtl/osc_autotrim_pkg.sv
package osc_autotrim_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_IEN  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] retry;
        logic [1:0] loop;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic ref_err;
        logic fail;
        logic lock;
    } stat_t;

    typedef struct packed {
        logic ref_err;
        logic fail;
    } ien_t;

    typedef enum logic [1:0] {
        CMP_IN   = 2'd0,
        CMP_LOW  = 2'd1,
        CMP_HIGH = 2'd2
    } cmp_e;

    function automatic int unsigned win_len(input logic [1:0] sel);
        return 32'd4 << sel;
    endfunction

    function automatic int unsigned retry_lim(input int unsigned base, input logic [1:0] sel);
        return base << sel;
    endfunction

endpackage

// File: rtl/osc_ref_edge.sv
module osc_ref_edge (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    output logic rise_o
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], ref_i};
    end

    assign rise_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/osc_period_meter.sv
module osc_period_meter #(
    parameter int ERR_LO = 337,
    parameter int ERR_HI = 1350,
    parameter int PER_W  = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             rise_i,
    output logic [PER_W-1:0] per_o,
    output logic             valid_o,
    output logic             err_o
);
    localparam logic [PER_W-1:0] LO_LIM = PER_W'(ERR_LO);
    localparam logic [PER_W-1:0] HI_LIM = PER_W'(ERR_HI);
    localparam logic [PER_W-1:0] SAT    = PER_W'(ERR_HI + 1);

    logic             armed_q;
    logic [PER_W-1:0] cnt_q;

    assign err_o   = armed_q && ((cnt_q > HI_LIM) || (rise_i && (cnt_q < LO_LIM)));
    assign valid_o = armed_q && rise_i && !err_o;
    assign per_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i || err_o) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (rise_i) begin
            armed_q <= 1'b1;
            cnt_q   <= PER_W'(1);
        end else if (armed_q && (cnt_q != SAT)) begin
            cnt_q   <= cnt_q + PER_W'(1);
        end
    end
endmodule

// File: rtl/osc_window_acc.sv
module osc_window_acc
    import osc_autotrim_pkg::*;
#(
    parameter int PER_W = 11,
    parameter int TOT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             valid_i,
    input  logic [PER_W-1:0] per_i,
    input  logic [1:0]       loop_i,
    output logic             done_o,
    output logic [TOT_W-1:0] total_o
);
    logic [5:0]       cnt_q;
    logic [TOT_W-1:0] sum_q;
    logic [5:0]       last;

    assign last    = 6'(win_len(loop_i) - 1);
    assign total_o = sum_q + TOT_W'(per_i);
    assign done_o  = valid_i && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run_i || done_o) begin
            cnt_q <= '0;
            sum_q <= '0;
        end else if (valid_i) begin
            cnt_q <= cnt_q + 6'd1;
            sum_q <= total_o;
        end
    end
endmodule

// File: rtl/osc_autotrim.sv
module osc_autotrim
    import osc_autotrim_pkg::*;
#(
    parameter int NOM        = 675,
    parameter int TOL        = 1,
    parameter int ERR_LO     = 337,
    parameter int ERR_HI     = 1350,
    parameter int RETRY_BASE = 64,
    parameter int TRIM_W     = 9,
    parameter int TRIM_INIT  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic [TRIM_W-1:0] trim_code_o,
    output logic              irq_o
);
    localparam int PER_W = $clog2(ERR_HI + 2);
    localparam int TOT_W = PER_W + 6;
    localparam int UPD_W = $clog2(RETRY_BASE * 8 + 1);
    localparam logic [TRIM_W-1:0] TRIM_MAX = '1;

    ctrl_t             ctrl_q;
    ien_t              ien_q;
    stat_t             stat_q;
    logic [TRIM_W-1:0] trim_q;
    logic [UPD_W-1:0]  upd_q;

    logic              rise;
    logic [PER_W-1:0]  per;
    logic              per_valid;
    logic              ref_bad;
    logic              win_done;
    logic [TOT_W-1:0]  win_total;
    logic [TOT_W-1:0]  lo_lim;
    logic [TOT_W-1:0]  hi_lim;
    logic [UPD_W-1:0]  upd_lim;
    cmp_e              cmp;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata_i[3:1];

    osc_ref_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .ref_i  (ref_clk_i),
        .rise_o (rise)
    );

    osc_period_meter #(.ERR_LO(ERR_LO), .ERR_HI(ERR_HI), .PER_W(PER_W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .run_i   (ctrl_q.en),
        .rise_i  (rise),
        .per_o   (per),
        .valid_o (per_valid),
        .err_o   (ref_bad)
    );

    osc_window_acc #(.PER_W(PER_W), .TOT_W(TOT_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .run_i   (ctrl_q.en),
        .valid_i (per_valid),
        .per_i   (per),
        .loop_i  (ctrl_q.loop),
        .done_o  (win_done),
        .total_o (win_total)
    );

    assign lo_lim  = TOT_W'(NOM - TOL) << ({1'b0, ctrl_q.loop} + 3'd2);
    assign hi_lim  = TOT_W'(NOM + TOL) << ({1'b0, ctrl_q.loop} + 3'd2);
    assign upd_lim = UPD_W'(retry_lim(RETRY_BASE, ctrl_q.retry));

    always_comb begin
        if (win_total < lo_lim)      cmp = CMP_LOW;
        else if (win_total > hi_lim) cmp = CMP_HIGH;
        else                         cmp = CMP_IN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ien_q  <= '0;
            stat_q <= '0;
            trim_q <= TRIM_W'(TRIM_INIT);
            upd_q  <= '0;
        end else begin
            if (reg_wr_i) begin
                case (reg_sel_e'(reg_addr_i))
                    REG_CTRL: begin
                        ctrl_q.retry <= reg_wdata_i[7:6];
                        ctrl_q.loop  <= reg_wdata_i[5:4];
                        ctrl_q.en    <= reg_wdata_i[0];
                    end
                    REG_IEN: begin
                        ien_q.ref_err <= reg_wdata_i[2];
                        ien_q.fail    <= reg_wdata_i[1];
                    end
                    REG_STAT: begin
                        if (reg_wdata_i[1]) stat_q.fail    <= 1'b0;
                        if (reg_wdata_i[2]) stat_q.ref_err <= 1'b0;
                    end
                    default: ;
                endcase
            end

            if (!ctrl_q.en) begin
                stat_q.lock <= 1'b0;
                upd_q       <= '0;
            end else if (ref_bad) begin
                stat_q.ref_err <= 1'b1;
                stat_q.lock    <= 1'b0;
                ctrl_q.en      <= 1'b0;
            end else if (win_done) begin
                if (cmp == CMP_IN) begin
                    stat_q.lock <= 1'b1;
                end else begin
                    stat_q.lock <= 1'b0;
                    if (upd_q == upd_lim) begin
                        stat_q.fail <= 1'b1;
                        ctrl_q.en   <= 1'b0;
                    end else begin
                        upd_q <= upd_q + UPD_W'(1);
                        if (cmp == CMP_LOW && trim_q != TRIM_MAX)
                            trim_q <= trim_q + TRIM_W'(1);
                        else if (cmp == CMP_HIGH && trim_q != '0)
                            trim_q <= trim_q - TRIM_W'(1);
                    end
                end
            end
        end
    end

    always_comb begin
        case (reg_sel_e'(reg_addr_i))
            REG_CTRL: reg_rdata_o = {ctrl_q.retry, ctrl_q.loop, 3'b000, ctrl_q.en};
            REG_IEN:  reg_rdata_o = {5'b00000, ien_q, 1'b0};
            REG_STAT: reg_rdata_o = {5'b00000, stat_q};
            default:  reg_rdata_o = 8'h00;
        endcase
    end

    assign trim_code_o = trim_q;
    assign irq_o       = (stat_q.fail & ien_q.fail) | (stat_q.ref_err & ien_q.ref_err);
endmodule

// File: rtl/osc_autotrim_chk.sv
module osc_autotrim_chk #(
    parameter int TRIM_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              lock,
    input logic              fail,
    input logic              ref_err,
    input logic              irq,
    input logic [TRIM_W-1:0] trim
);
    AST_TRIM_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(trim) |-> (TRIM_W'(trim - $past(trim)) == TRIM_W'(1) || TRIM_W'($past(trim) - trim) == TRIM_W'(1))); // R5
    AST_LOCK_TRIM_STILL: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $stable(trim)); // R4
    AST_FAIL_HALTS: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> (!en && $stable(trim))); // R6
    AST_REF_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_err) |-> (!en && !lock && $stable(trim))); // R7
    AST_LOCK_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!fail && !ref_err) |-> !irq); // R9
    AST_IDLE_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
        !en |=> !lock); // R10
    AST_IDLE_TRIM_HELD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(trim)); // R10
endmodule

bind osc_autotrim osc_autotrim_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl_q.en),
    .lock    (stat_q.lock),
    .fail    (stat_q.fail),
    .ref_err (stat_q.ref_err),
    .irq     (irq_o),
    .trim    (trim_code_o)
);

// File: tb/tb_osc_autotrim.sv
module tb_osc_autotrim;
    localparam int NOM = 40, TOL = 1, ELO = 20, EHI = 80, RB = 4, TW = 6, TINIT = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_clk = 1'b0;
    logic          wr = 1'b0;
    logic [1:0]    addr = 2'd2;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic [TW-1:0] trim;
    logic          irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done_flag = 0;
    int ref_mode = 0, ref_per = 40, target = 35;

    osc_autotrim #(.NOM(NOM), .TOL(TOL), .ERR_LO(ELO), .ERR_HI(EHI), .RETRY_BASE(RB),
                   .TRIM_W(TW), .TRIM_INIT(TINIT)) dut (
        .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trim_code_o(trim), .irq_o(irq));

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // reference model
    int m_en, m_loop, m_retry, m_ie1, m_ie2, m_lock, m_fail, m_err, m_trim;
    int h1, h2, h3, m_armed, m_per, m_sum, m_cnt, m_upd;

    function automatic int mread(input int a);
        case (a)
            0: return (m_retry << 6) | (m_loop << 4) | m_en;
            1: return (m_ie2 << 2) | (m_ie1 << 1);
            2: return (m_err << 2) | (m_fail << 1) | m_lock;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_en = 0; m_loop = 0; m_retry = 0; m_ie1 = 0; m_ie2 = 0;
            m_lock = 0; m_fail = 0; m_err = 0; m_trim = TINIT;
            h1 = 0; h2 = 0; h3 = 0; m_armed = 0; m_per = 0; m_sum = 0; m_cnt = 0; m_upd = 0;
        end else begin
            bit rise;
            int n_en, n_lock, n_armed, n_per, n_sum, n_cnt, n_upd, n_trim, win, lim, tot;
            rise = (h2 == 1) && (h3 == 0);
            n_en = m_en; n_lock = m_lock; n_armed = m_armed; n_per = m_per;
            n_sum = m_sum; n_cnt = m_cnt; n_upd = m_upd; n_trim = m_trim;
            if (wr) begin
                if (addr == 0) begin
                    n_en = wdata[0]; m_loop = wdata[5:4]; m_retry = wdata[7:6];
                end else if (addr == 1) begin
                    m_ie1 = wdata[1]; m_ie2 = wdata[2];
                end else if (addr == 2) begin
                    if (wdata[1]) m_fail = 0;
                    if (wdata[2]) m_err = 0;
                end
            end
            if (m_en == 0) begin
                n_armed = 0; n_per = 0; n_sum = 0; n_cnt = 0; n_upd = 0; n_lock = 0;
            end else if (m_armed && (m_per > EHI || (rise && m_per < ELO))) begin
                m_err = 1; n_en = 0; n_lock = 0;
                n_armed = 0; n_per = 0; n_sum = 0; n_cnt = 0;
            end else if (rise) begin
                if (m_armed) begin
                    win = 4 << (m_loop & 3);
                    if (m_cnt == win - 1) begin
                        tot = m_sum + m_per; n_sum = 0; n_cnt = 0;
                        lim = RB << (m_retry & 3);
                        if (tot >= (NOM - TOL) * win && tot <= (NOM + TOL) * win) n_lock = 1;
                        else begin
                            n_lock = 0;
                            if (m_upd == lim) begin m_fail = 1; n_en = 0; end
                            else begin
                                n_upd = m_upd + 1;
                                if (tot < (NOM - TOL) * win) n_trim = (m_trim == (1 << TW) - 1) ? m_trim : m_trim + 1;
                                else n_trim = (m_trim == 0) ? 0 : m_trim - 1;
                            end
                        end
                    end else begin
                        n_sum = m_sum + m_per; n_cnt = m_cnt + 1;
                    end
                end
                n_armed = 1; n_per = 1;
            end else if (m_armed) begin
                n_per = (m_per == EHI + 1) ? m_per : m_per + 1;
            end
            m_en = n_en; m_lock = n_lock; m_armed = n_armed; m_per = n_per;
            m_sum = n_sum; m_cnt = n_cnt; m_upd = n_upd; m_trim = n_trim;
            h3 = h2; h2 = h1; h1 = int'(ref_clk);
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            chk(int'(trim) == m_trim, "R5 trim vs model", int'(trim), m_trim);
            chk(int'(irq) == ((m_fail & m_ie1) | (m_err & m_ie2)), "R9 irq vs model", int'(irq),
                (m_fail & m_ie1) | (m_err & m_ie2));
            chk(int'(rdata) == mread(int'(addr)), "R8 readback vs model", int'(rdata), mread(int'(addr)));
        end
    end

    // oscillator stand-in: period in clk cycles follows the trim code
    initial begin
        @(negedge rst);
        forever begin
            int p;
            p = (ref_mode == 0) ? NOM + int'(trim) - target : ref_per;
            repeat (p / 2) @(negedge clk);
            #1 ref_clk = 1'b0;
            repeat (p - p / 2) @(negedge clk);
            #1 ref_clk = 1'b1;
        end
    end

    task automatic wreg(input int a, input int d);
        @(negedge clk); #1 wr = 1'b1; addr = 2'(a); wdata = 8'(d);
        @(negedge clk); #1 wr = 1'b0; addr = 2'd2; wdata = 8'h00;
    endtask

    task automatic rreg(input int a, output int d);
        @(negedge clk); #1 addr = 2'(a);
        @(negedge clk); d = int'(rdata);
        #1 addr = 2'd2;
    endtask

    task automatic wait_stat(input int bitn, input int maxc, output bit seen);
        seen = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (rdata[bitn]) begin seen = 1; break; end
        end
    endtask

    task automatic wait_trim_change(input int maxc, output int at);
        logic [TW-1:0] prev;
        prev = trim; at = -1;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (trim != prev) begin at = cyc; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int v, t0, a, b;
        bit seen;
        repeat (5) @(posedge clk);
        @(negedge clk); #1 rst = 1'b0;

        // R1 reset state
        for (int r = 0; r < 3; r++) begin
            rreg(r, v);
            chk(v == 0, "R1 register reset value", v, 0);
        end
        chk(int'(trim) == TINIT, "R1 trim reset", int'(trim), TINIT);
        chk(irq == 1'b0, "R1 irq reset", int'(irq), 0);

        // R2 control layout, unused bits read 0
        wreg(0, 8'h9E);
        rreg(0, v);
        chk(v == 8'h90, "R2 control readback", v, 8'h90);
        wreg(0, 0);

        // R9 interrupt-enable layout
        wreg(1, 8'hFF);
        rreg(1, v);
        chk(v == 8'h06, "R9 enable readback", v, 8'h06);

        // R8 lock bit not writable
        wreg(2, 8'h07);
        rreg(2, v);
        chk(v == 0, "R8 status write has no set effect", v, 0);

        // R4 converge and lock
        ref_mode = 0; target = 35;
        wreg(0, 8'hC1);
        wait_stat(0, 6000, seen);
        chk(seen, "R4 lock reached", int'(seen), 1);
        chk(int'(trim) >= 34 && int'(trim) <= 36, "R4 trim near target", int'(trim), 35);
        t0 = int'(trim);
        repeat (600) @(negedge clk);
        chk(int'(trim) == t0 && rdata[0], "R4 lock holds trim", int'(trim), t0);
        chk(irq == 1'b0, "R9 lock raises no interrupt", int'(irq), 0);

        // R10 disable drops lock and holds trim
        wreg(0, 8'h00);
        @(negedge clk);
        chk(rdata[0] == 1'b0, "R10 lock cleared when disabled", int'(rdata[0]), 0);
        repeat (300) @(negedge clk);
        chk(int'(trim) == t0, "R10 trim held when disabled", int'(trim), t0);

        // R6 retry limit 4 ends in failure
        target = 10;
        wreg(0, 8'h01);
        wait_stat(1, 6000, seen);
        chk(seen, "R6 fail flag set", int'(seen), 1);
        @(negedge clk);
        chk(int'(trim) == t0 - 4, "R6 trim after 4 updates", int'(trim), t0 - 4);
        rreg(0, v);
        chk((v & 1) == 0, "R6 enable cleared", v & 1, 0);
        chk(irq == 1'b1, "R9 fail interrupt", int'(irq), 1);

        // R8 / R9 clear semantics and masking
        wreg(2, 8'h05);
        rreg(2, v);
        chk(v == 8'h02, "R8 write 0 keeps fail", v, 8'h02);
        wreg(1, 8'h04);
        @(negedge clk);
        chk(irq == 1'b0, "R9 masked fail", int'(irq), 0);
        wreg(2, 8'h02);
        rreg(2, v);
        chk(v == 0, "R8 write 1 clears fail", v, 0);
        wreg(1, 8'h06);

        // R3 window of 4 periods, R5 saturation at zero
        ref_mode = 1; ref_per = 50;
        wreg(0, 8'hC1);
        wait_trim_change(3000, a);
        wait_trim_change(3000, b);
        chk(b - a == 4 * 50, "R3 decision spacing loop=0", b - a, 200);
        wait_stat(1, 12000, seen);
        chk(seen, "R6 fail after 32 updates", int'(seen), 1);
        @(negedge clk);
        chk(trim == '0, "R5 trim saturates at zero", int'(trim), 0);
        wreg(2, 8'h06);

        // R3 window of 16 periods, trim rising
        ref_per = 30;
        wreg(0, 8'hE1);
        wait_trim_change(4000, a);
        wait_trim_change(4000, b);
        chk(b - a == 16 * 30, "R3 decision spacing loop=2", b - a, 480);
        chk(int'(trim) == 2, "R5 trim steps up", int'(trim), 2);
        wreg(0, 8'h00);

        // R7 short period
        t0 = int'(trim);
        ref_per = 15;
        repeat (40) @(negedge clk);
        wreg(0, 8'h11);
        wait_stat(2, 400, seen);
        chk(seen, "R7 short period flagged", int'(seen), 1);
        @(negedge clk);
        chk(irq == 1'b1, "R9 reference-error interrupt", int'(irq), 1);
        chk(int'(trim) == t0, "R7 trim unchanged", int'(trim), t0);
        rreg(0, v);
        chk((v & 1) == 0, "R7 enable cleared (short)", v & 1, 0);
        wreg(2, 8'h04);
        rreg(2, v);
        chk(v == 0, "R8 reference error cleared", v, 0);

        // R7 long period
        ref_per = 90;
        repeat (100) @(negedge clk);
        wreg(0, 8'h01);
        wait_stat(2, 600, seen);
        chk(seen, "R7 long period flagged", int'(seen), 1);
        rreg(0, v);
        chk((v & 1) == 0, "R7 enable cleared (long)", v & 1, 0);

        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule